// File: doc/BRIEF.md
# Prioritized Level-Sensitive Interrupt Controller

This block gathers up to 64 level-sensitive interrupt lines into groups of 32. Each group has an enable mask and a route-select register. A line that is asserted and enabled goes either to the normal interrupt request output or to the fast interrupt output, as its route bit selects. Software reads three views of each group: the raw line levels, the lines that are enabled and routed to the normal output, and the lines that are enabled and routed to the fast output.

A programmable table of priority slots names one source for each slot. The controller picks the lowest-numbered valid slot whose source is asserted, enabled and routed to the normal output. It reports that source in a read-only winner register, which carries a valid flag. A control bit decides whether any asserted line, or only an enabled one, raises the idle-wake output. The register port is a single-cycle read/write interface with byte addresses. Read data is registered.

Top module: `irq_ctl`

## Requirements
- R1: After reset, irq_o, fiq_o and wake_o are 0, and every mask, route and control register reads 0. The winner register (0x018) and every priority slot read 0.
- R2: A line is enabled only when its mask bit is 1. Masks are at 0x004 (lines 0-31) and 0x0A0 (lines 32-63). Writing 0 to a mask disables every line of that group. The raw registers at 0x010 and 0x0AC show all asserted lines, whatever the mask.
- R3: Route bit 0 selects the normal output and 1 selects the fast output. Route registers are at 0x008 and 0x0A4. The normal-pending registers (0x000, 0x09C) read line & mask & ~route. The fast-pending registers (0x00C, 0x0A8) read line & mask & route.
- R4: irq_o is the OR of all normal-pending bits and fiq_o is the OR of all fast-pending bits. Each is registered, so it changes one clock edge after its inputs change.
- R5: Priority slot i sits at 0x01C+4*i for i<32 and at 0x0B0+4*(i-32) for 32<=i<64. Bit 31 is the valid flag and bits 5:0 hold the source number. Other bits read 0.
- R6: The winner register at 0x018 sets bit 31 and places the source number in bits 30:16 when a valid slot's source is asserted, enabled and routed to the normal output. Among such slots, the lowest-numbered one wins. Otherwise the register reads 0.
- R7: Control bit 0 is at 0x014. When it is 1, wake_o (registered) is the OR of the asserted and enabled lines. When it is 0, wake_o is the OR of all asserted lines.
- R8: Reads from unmapped offsets return 0, and writes to them are ignored. Offset 0x130 and above 0x12C are unmapped, apart from the mapped slots. Writes to the pending, raw and winner registers change nothing.
- R9: Read data appears on rdata at the first clock edge after a cycle with rd_en high. rdata is 0 after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Interrupt line levels, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |

## Verification
The checker watches every cycle for the one-edge lag between the pending vectors and irq_o and fiq_o, and for the idle-wake rule under each control setting. It also checks that the reported winner is always a line that is pending on the normal output, and that the outputs are quiet just after reset. Only the bench's scenarios can show the register layout, which slot wins when several compete, read-back of slot contents, and that writes to read-only or unmapped offsets leave the visible state unchanged.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned OFF_IRQ  = 'h00;
  localparam int unsigned OFF_MASK = 'h04;
  localparam int unsigned OFF_LVL  = 'h08;
  localparam int unsigned OFF_FIQ  = 'h0C;
  localparam int unsigned OFF_RAW  = 'h10;
  localparam int unsigned ADR_CTRL = 'h14;
  localparam int unsigned ADR_HP   = 'h18;

  function automatic int unsigned bank_base(int unsigned b);
    case (b)
      0:       return 'h000;
      1:       return 'h09C;
      default: return 'h130;
    endcase
  endfunction

  function automatic int unsigned slot_addr(int unsigned i);
    if (i < 32)      return 'h01C + 4 * i;
    else if (i < 64) return 'h0B0 + 4 * (i - 32);
    else             return 'h144 + 4 * (i - 64);
  endfunction
endpackage

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int unsigned BANK = 0,
  parameter int unsigned AW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [31:0]   src,
  output logic [31:0]   mask_q,
  output logic [31:0]   irq_p,
  output logic [31:0]   fiq_p,
  output logic [DW-1:0] rd_val
);
  localparam logic [AW-1:0] BASE   = AW'(bank_base(BANK));
  localparam logic [AW-1:0] A_IRQ  = BASE + AW'(OFF_IRQ);
  localparam logic [AW-1:0] A_MASK = BASE + AW'(OFF_MASK);
  localparam logic [AW-1:0] A_LVL  = BASE + AW'(OFF_LVL);
  localparam logic [AW-1:0] A_FIQ  = BASE + AW'(OFF_FIQ);
  localparam logic [AW-1:0] A_RAW  = BASE + AW'(OFF_RAW);

  logic [31:0] route_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK) mask_q  <= wdata;
      if (addr == A_LVL)  route_q <= wdata;
    end
  end

  assign irq_p = src & mask_q & ~route_q;
  assign fiq_p = src & mask_q & route_q;

  always_comb begin
    rd_val = '0;
    if      (addr == A_IRQ)  rd_val = irq_p;
    else if (addr == A_MASK) rd_val = mask_q;
    else if (addr == A_LVL)  rd_val = route_q;
    else if (addr == A_FIQ)  rd_val = fiq_p;
    else if (addr == A_RAW)  rd_val = src;
  end
endmodule

// File: rtl/icu_prio.sv
module icu_prio
  import icu_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  parameter int unsigned AW   = 9,
  localparam int unsigned SW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic            wvld,
  input  logic [SW-1:0]   wnum,
  input  logic [NSRC-1:0] cand,
  output logic            hv,
  output logic [SW-1:0]   hnum,
  output logic [DW-1:0]   rd_val
);
  logic [NSRC-1:0] vld_q;
  logic [SW-1:0]   num_q [NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < NSRC; i++) num_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NSRC; i++) begin
        if (addr == AW'(slot_addr(i))) begin
          vld_q[i] <= wvld;
          num_q[i] <= wnum;
        end
      end
    end
  end

  // lowest-numbered matching slot wins: scan downward so it is assigned last
  always_comb begin
    hv   = 1'b0;
    hnum = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vld_q[i] && (int'(num_q[i]) < NSRC) && cand[num_q[i]]) begin
        hv   = 1'b1;
        hnum = num_q[i];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (addr == AW'(slot_addr(i)))
        rd_val = {vld_q[i], {(DW-1-SW){1'b0}}, num_q[i]};
    end
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import icu_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  parameter int unsigned AW   = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            wake_o
);
  localparam int unsigned NBANK = NSRC / 32;
  localparam int unsigned SW    = $clog2(NSRC);

  logic [NSRC-1:0] mask_all, irq_pend, fiq_pend;
  logic [DW-1:0]   bank_rd [NBANK];
  logic [DW-1:0]   slot_rd, rd_mux;
  logic            hp_v, ctrl_en;
  logic [SW-1:0]   hp_num;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    icu_bank #(.BANK(g), .AW(AW)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .src(src_lvl[32*g +: 32]),
      .mask_q(mask_all[32*g +: 32]),
      .irq_p(irq_pend[32*g +: 32]),
      .fiq_p(fiq_pend[32*g +: 32]),
      .rd_val(bank_rd[g])
    );
  end

  icu_prio #(.NSRC(NSRC), .AW(AW)) u_prio (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wvld(wdata[31]), .wnum(wdata[SW-1:0]),
    .cand(irq_pend), .hv(hp_v), .hnum(hp_num), .rd_val(slot_rd)
  );

  always_comb begin
    rd_mux = slot_rd;
    for (int b = 0; b < NBANK; b++) rd_mux = rd_mux | bank_rd[b];
    if (addr == AW'(ADR_CTRL)) rd_mux = {31'b0, ctrl_en};
    if (addr == AW'(ADR_HP))   rd_mux = {hp_v, 15'(hp_num), 16'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
      wake_o  <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr_en && addr == AW'(ADR_CTRL)) ctrl_en <= wdata[0];
      irq_o  <= |irq_pend;
      fiq_o  <= |fiq_pend;
      wake_o <= ctrl_en ? |(src_lvl & mask_all) : |src_lvl;
      rdata  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int unsigned NSRC = 64,
  localparam int unsigned SW  = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_lvl,
  input logic [NSRC-1:0] mask_all,
  input logic [NSRC-1:0] irq_pend,
  input logic [NSRC-1:0] fiq_pend,
  input logic            ctrl_en,
  input logic            hp_v,
  input logic [SW-1:0]   hp_num,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            wake_o
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !fiq_o && !wake_o));

  // R4
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (irq_o == $past(|irq_pend)));

  // R4
  fiq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (fiq_o == $past(|fiq_pend)));

  // R6
  winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
    hp_v |-> irq_pend[hp_num]);

  // R6
  no_winner_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pend == '0) |-> !hp_v);

  // R7
  wake_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |->
      (wake_o == ($past(ctrl_en) ? $past(|(src_lvl & mask_all)) : $past(|src_lvl))));
endmodule

bind irq_ctl irq_ctl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .src_lvl(src_lvl), .mask_all(mask_all),
  .irq_pend(irq_pend), .fiq_pend(fiq_pend), .ctrl_en(ctrl_en),
  .hp_v(hp_v), .hp_num(hp_num), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
);

// File: tb/irq_ctl_test.sv
module irq_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;
  localparam int AW   = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_lvl = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq_o, fiq_o, wake_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl #(.NSRC(NSRC), .AW(AW)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    check("R1 wake_o", 32'(wake_o), 0);
    rd_chk("R1 mask0", 'h004, 0);
    rd_chk("R1 route1", 'h0A4, 0);
    rd_chk("R1 ctrl", 'h014, 0);
    rd_chk("R1 winner", 'h018, 0);
    rd_chk("R1 slot0", 'h01C, 0);
    rd_chk("R1 slot63", 'h12C, 0);
  endtask

  task automatic t_mask_raw();
    @(negedge clk);
    src_lvl = '0; src_lvl[3] = 1'b1; src_lvl[40] = 1'b1;
    rd_chk("R2 raw0", 'h010, 32'h8);
    rd_chk("R2 raw1", 'h0AC, 32'h100);
    rd_chk("R2 pend0 masked", 'h000, 0);
    wr('h004, 32'h8);
    rd_chk("R2 pend0 enabled", 'h000, 32'h8);
    rd_chk("R2 pend1 masked", 'h09C, 0);
    wr('h0A0, 32'h100);
    rd_chk("R2 pend1 enabled", 'h09C, 32'h100);
    wr('h004, 0);
    wr('h0A0, 0);
    rd_chk("R2 pend0 disabled", 'h000, 0);
    rd_chk("R2 raw0 unaffected", 'h010, 32'h8);
  endtask

  task automatic t_route();
    @(negedge clk);
    src_lvl = '0; src_lvl[3] = 1'b1; src_lvl[4] = 1'b1;
    wr('h004, 32'h18);
    wr('h008, 32'h10);
    rd_chk("R3 normal pend", 'h000, 32'h8);
    rd_chk("R3 fast pend", 'h00C, 32'h10);
    check("R4 irq_o set", 32'(irq_o), 1);
    check("R4 fiq_o set", 32'(fiq_o), 1);
    @(negedge clk);
    src_lvl = '0;
    #1;
    check("R4 irq_o lag", 32'(irq_o), 1);
    @(negedge clk);
    check("R4 irq_o clear", 32'(irq_o), 0);
    check("R4 fiq_o clear", 32'(fiq_o), 0);
    wr('h008, 0);
    wr('h004, 0);
  endtask

  task automatic t_prio();
    wr('h01C, 32'h8000_0028);
    wr('h020, 32'h8000_0003);
    wr('h0B0, 32'h8000_0005);
    rd_chk("R5 slot0", 'h01C, 32'h8000_0028);
    rd_chk("R5 slot32", 'h0B0, 32'h8000_0005);
    wr('h004, 32'hFFFF_FFFF);
    wr('h0A0, 32'hFFFF_FFFF);
    @(negedge clk);
    src_lvl = '0; src_lvl[3] = 1'b1;
    rd_chk("R6 single", 'h018, 32'h8003_0000);
    src_lvl[40] = 1'b1;
    rd_chk("R6 slot0 wins", 'h018, 32'h8028_0000);
    src_lvl = '0; src_lvl[5] = 1'b1;
    rd_chk("R6 slot32", 'h018, 32'h8005_0000);
    src_lvl = '0; src_lvl[3] = 1'b1; src_lvl[9] = 1'b1;
    wr('h008, 32'h8);
    rd_chk("R6 fast routed ignored", 'h018, 0);
    wr('h008, 0);
    wr('h020, 32'h0000_0003);
    rd_chk("R6 invalid slot", 'h018, 0);
    @(negedge clk);
    src_lvl = '0;
    wr('h004, 0);
    wr('h0A0, 0);
  endtask

  task automatic t_wake();
    @(negedge clk);
    src_lvl = '0; src_lvl[7] = 1'b1;
    @(negedge clk);
    check("R7 any line wakes", 32'(wake_o), 1);
    wr('h014, 1);
    @(negedge clk);
    check("R7 masked no wake", 32'(wake_o), 0);
    rd_chk("R7 ctrl", 'h014, 1);
    wr('h004, 32'h80);
    @(negedge clk);
    check("R7 enabled wakes", 32'(wake_o), 1);
    wr('h004, 0);
    wr('h014, 0);
    @(negedge clk);
    src_lvl = '0;
  endtask

  task automatic t_unmapped();
    wr('h130, 32'hDEAD_BEEF);
    rd_chk("R8 unmapped read", 'h130, 0);
    rd_chk("R8 unmapped high", 'h1F8, 0);
    wr('h004, 32'h2);
    @(negedge clk);
    src_lvl = '0; src_lvl[1] = 1'b1;
    wr('h000, 32'hFFFF_FFFF);
    wr('h010, 32'hFFFF_FFFF);
    wr('h018, 32'hFFFF_FFFF);
    rd_chk("R8 pend write ignored", 'h000, 32'h2);
    rd_chk("R8 raw write ignored", 'h010, 32'h2);
    rd_chk("R8 mask intact", 'h004, 32'h2);
    rd_chk("R8 winner write ignored", 'h018, 0);
    @(negedge clk);
    check("R9 rdata idle zero", rdata, 0);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'('h004);
    #1;
    check("R9 not before edge", rdata, 0);
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 after edge", rdata, 32'h2);
    src_lvl = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_raw();
    t_route();
    t_prio();
    t_wake();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule